// File: doc/BRIEF.md
# Four-Mode Timer/Counter

This block is a 16-bit timer/counter held in two byte registers. It advances either on a one-cycle internal tick strobe or on falling edges of an external count pin, and a run bit plus an optional gate pin decide whether it may advance at all. A two-bit mode input picks one of four arrangements of the same register pair.

The four arrangements are a 13-bit counter, a plain 16-bit counter, an 8-bit counter that reloads itself, and a split arrangement that acts as two independent 8-bit timers. In the 13-bit mode the low five bits of the low byte act as a prescaler feeding the high byte. In the reload mode the high byte holds the reload value. In split mode the high byte has its own run input and its own overflow flag, and it always counts internal ticks.

Both bytes can be written directly at any time. Overflow flags stay set until they are cleared, so a surrounding controller can poll them or turn them into interrupts.

Top module: `tmr_quad_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, both count bytes and both overflow flags are cleared to zero. `rst` is synchronous and active high.
- R2: With `mode_i` = 1 (16-bit mode), each enabled count step adds one to {`cnt_hi_o`,`cnt_lo_o`}. A step taken from 0xFFFF gives 0x0000 and sets `ovf_o`.
- R3: With `mode_i` = 0 (13-bit mode), a step adds one to bits [4:0] of the low byte. When those bits are all ones, they wrap to zero and the high byte increments. A wrap of the high byte from 0xFF sets `ovf_o`. Low-byte bits [7:5] are left unchanged.
- R4: With `mode_i` = 2 (reload mode), a step adds one to the low byte. A step taken from 0xFF loads the low byte from the high byte and sets `ovf_o`. The high byte never counts in this mode.
- R5: With `mode_i` = 3 (split mode), the low byte steps under the unit's normal enable and sets `ovf_o` when it wraps from 0xFF. The high byte steps on every `tick_i` while `hi_run_i` is high, and sets `ovf2_o` when it wraps from 0xFF.
- R6: When `ext_sel_i` is high, the source of count steps is a 1-to-0 transition of `ext_i`, found after two synchronizing flops. `tick_i` then has no effect on the main count. When `ext_sel_i` is low, each cycle with `tick_i` high is one step.
- R7: When `gate_en_i` is high, the main count steps only while `gate_i` is high, in addition to the run condition.
- R8: While `run_i` is low, the main count does not change. This covers the low byte in split mode and the whole register pair in the other modes.
- R9: Each overflow flag stays set until its clear input (`clr_ovf_i` or `clr_ovf2_i`) is high at a clock edge. If an overflow and a clear happen in the same cycle, the flag is set.
- R10: A byte write (`wr_lo_i` or `wr_hi_i`, data on `wdata_i`) takes effect at the next edge. In modes 0 to 2, any write cancels that cycle's count step. In split mode, a write cancels only the step of the byte being written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | 0: 13-bit, 1: 16-bit, 2: 8-bit reload, 3: split |
| run_i | input | 1 | Run control of the main count |
| hi_run_i | input | 1 | Run control of the high byte in split mode |
| ext_sel_i | input | 1 | 1: count external falling edges, 0: count ticks |
| gate_en_i | input | 1 | 1: main count also needs gate_i high |
| gate_i | input | 1 | Gate pin |
| tick_i | input | 1 | Internal tick strobe, one cycle per tick |
| ext_i | input | 1 | External count pin (asynchronous) |
| wr_lo_i | input | 1 | Write strobe for the low byte |
| wr_hi_i | input | 1 | Write strobe for the high byte |
| wdata_i | input | 8 | Write data |
| clr_ovf_i | input | 1 | Clear main overflow flag |
| clr_ovf2_i | input | 1 | Clear split high-byte overflow flag |
| cnt_lo_o | output | 8 | Low count byte |
| cnt_hi_o | output | 8 | High count byte |
| ovf_o | output | 1 | Main overflow flag |
| ovf2_o | output | 1 | High-byte overflow flag (split mode) |

## Verification
Some properties are checked on every cycle. The count freezes while the run bit is low or the gate closes the count, outside split mode. Flags are sticky. The main flag can rise only after the run bit was high, and the second flag can rise only in split mode. Reset clears everything. The exact wrap points need directed scenarios: the prescaler carry in 13-bit mode, the reload value and the untouched high byte in reload mode, and the 0xFFFF rollover. The same applies to the independence of the two split halves, counting external edges while ticks are ignored, and write priority over a step.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    parameter int BYTE_W = 8;
    parameter int PRE_W  = 5;
    parameter int SYNC_N = 2;

    localparam int PAIR_W = 2 * BYTE_W;

    typedef enum logic [1:0] {
        MODE_PRE13   = 2'd0,
        MODE_FULL16  = 2'd1,
        MODE_RELOAD8 = 2'd2,
        MODE_SPLIT   = 2'd3
    } tmr_mode_e;

    typedef struct packed {
        logic [BYTE_W-1:0] lo;
        logic [BYTE_W-1:0] hi;
    } tmr_pair_s;

    typedef struct packed {
        tmr_pair_s pair;
        logic      wrap_main;
        logic      wrap_hi;
    } tmr_next_s;

    function automatic logic all_ones_byte(input logic [BYTE_W-1:0] v);
        return &v;
    endfunction

endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync
    import tmr_pkg::*;
#(
    parameter int STAGES = SYNC_N
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_i,
    output logic fall_o
);
    localparam int LAST = STAGES;

    logic [LAST:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= 1'b1;
        else     chain[0] <= pin_i;
    end

    for (genvar g = 1; g <= LAST; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[g] <= 1'b1;
            else     chain[g] <= chain[g-1];
        end
    end

    // previous synchronized sample high, current one low
    assign fall_o = chain[LAST] & ~chain[LAST-1];

endmodule

// File: rtl/tmr_step_ctrl.sv
module tmr_step_ctrl (
    input  logic run_i,
    input  logic hi_run_i,
    input  logic ext_sel_i,
    input  logic gate_en_i,
    input  logic gate_i,
    input  logic tick_i,
    input  logic ext_fall_i,
    output logic main_step_o,
    output logic hi_step_o
);
    logic src_pulse;
    logic allowed;

    always_comb begin
        src_pulse   = ext_sel_i ? ext_fall_i : tick_i;
        allowed     = run_i & (~gate_en_i | gate_i);
        main_step_o = src_pulse & allowed;
        hi_step_o   = tick_i & hi_run_i;
    end

endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  tmr_mode_e         mode,
    input  logic              main_step,
    input  logic              hi_step,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              clr_ovf,
    input  logic              clr_ovf2,
    output tmr_pair_s         cur,
    output logic              ovf,
    output logic              ovf2
);
    tmr_next_s nxt;
    logic      any_wr;

    always_comb begin
        any_wr        = wr_lo | wr_hi;
        nxt.pair      = cur;
        nxt.wrap_main = 1'b0;
        nxt.wrap_hi   = 1'b0;
        unique case (mode)
            MODE_PRE13: begin
                if (main_step && !any_wr) begin
                    if (&cur.lo[PRE_W-1:0]) begin
                        nxt.pair.lo[PRE_W-1:0] = '0;
                        nxt.pair.hi            = cur.hi + BYTE_W'(1);
                        nxt.wrap_main          = all_ones_byte(cur.hi);
                    end else begin
                        nxt.pair.lo[PRE_W-1:0] = cur.lo[PRE_W-1:0] + PRE_W'(1);
                    end
                end
            end
            MODE_FULL16: begin
                if (main_step && !any_wr) begin
                    {nxt.pair.hi, nxt.pair.lo} = {cur.hi, cur.lo} + PAIR_W'(1);
                    nxt.wrap_main = all_ones_byte(cur.hi) & all_ones_byte(cur.lo);
                end
            end
            MODE_RELOAD8: begin
                if (main_step && !any_wr) begin
                    if (all_ones_byte(cur.lo)) begin
                        nxt.pair.lo   = cur.hi;
                        nxt.wrap_main = 1'b1;
                    end else begin
                        nxt.pair.lo = cur.lo + BYTE_W'(1);
                    end
                end
            end
            MODE_SPLIT: begin
                if (main_step && !wr_lo) begin
                    nxt.pair.lo   = cur.lo + BYTE_W'(1);
                    nxt.wrap_main = all_ones_byte(cur.lo);
                end
                if (hi_step && !wr_hi) begin
                    nxt.pair.hi = cur.hi + BYTE_W'(1);
                    nxt.wrap_hi = all_ones_byte(cur.hi);
                end
            end
            default: ;
        endcase
        if (wr_lo) nxt.pair.lo = wdata;
        if (wr_hi) nxt.pair.hi = wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur  <= '0;
            ovf  <= 1'b0;
            ovf2 <= 1'b0;
        end else begin
            cur  <= nxt.pair;
            ovf  <= nxt.wrap_main | (ovf & ~clr_ovf);
            ovf2 <= nxt.wrap_hi | (ovf2 & ~clr_ovf2);
        end
    end

endmodule

// File: rtl/tmr_quad_unit.sv
module tmr_quad_unit
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        mode_i,
    input  logic              run_i,
    input  logic              hi_run_i,
    input  logic              ext_sel_i,
    input  logic              gate_en_i,
    input  logic              gate_i,
    input  logic              tick_i,
    input  logic              ext_i,
    input  logic              wr_lo_i,
    input  logic              wr_hi_i,
    input  logic [BYTE_W-1:0] wdata_i,
    input  logic              clr_ovf_i,
    input  logic              clr_ovf2_i,
    output logic [BYTE_W-1:0] cnt_lo_o,
    output logic [BYTE_W-1:0] cnt_hi_o,
    output logic              ovf_o,
    output logic              ovf2_o
);
    logic      ext_fall;
    logic      main_step;
    logic      hi_step;
    tmr_pair_s pair_q;
    tmr_mode_e mode_e;

    assign mode_e = tmr_mode_e'(mode_i);

    tmr_edge_sync #(.STAGES(SYNC_N)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .pin_i  (ext_i),
        .fall_o (ext_fall)
    );

    tmr_step_ctrl u_ctrl (
        .run_i       (run_i),
        .hi_run_i    (hi_run_i),
        .ext_sel_i   (ext_sel_i),
        .gate_en_i   (gate_en_i),
        .gate_i      (gate_i),
        .tick_i      (tick_i),
        .ext_fall_i  (ext_fall),
        .main_step_o (main_step),
        .hi_step_o   (hi_step)
    );

    tmr_datapath u_dp (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode_e),
        .main_step (main_step),
        .hi_step   (hi_step),
        .wr_lo     (wr_lo_i),
        .wr_hi     (wr_hi_i),
        .wdata     (wdata_i),
        .clr_ovf   (clr_ovf_i),
        .clr_ovf2  (clr_ovf2_i),
        .cur       (pair_q),
        .ovf       (ovf_o),
        .ovf2      (ovf2_o)
    );

    assign cnt_lo_o = pair_q.lo;
    assign cnt_hi_o = pair_q.hi;

endmodule

// File: rtl/tmr_quad_chk.sv
module tmr_quad_chk
    import tmr_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [1:0]        mode_i,
    input logic              run_i,
    input logic              gate_en_i,
    input logic              gate_i,
    input logic              wr_lo_i,
    input logic              wr_hi_i,
    input logic              clr_ovf_i,
    input logic              clr_ovf2_i,
    input logic [BYTE_W-1:0] cnt_lo_o,
    input logic [BYTE_W-1:0] cnt_hi_o,
    input logic              ovf_o,
    input logic              ovf2_o
);
    logic quiet;
    assign quiet = !wr_lo_i && !wr_hi_i && (mode_i != 2'd3);

    // R1
    a_r1_reset_clear: assert property (@(posedge clk)
        $past(rst) |-> (cnt_lo_o == '0 && cnt_hi_o == '0 && !ovf_o && !ovf2_o));

    // R8
    a_r8_halt_freezes: assert property (@(posedge clk) disable iff (rst)
        (!run_i && quiet) |=> ($stable(cnt_lo_o) && $stable(cnt_hi_o)));

    // R7
    a_r7_gate_closed: assert property (@(posedge clk) disable iff (rst)
        (gate_en_i && !gate_i && quiet) |=> ($stable(cnt_lo_o) && $stable(cnt_hi_o)));

    // R9
    a_r9_main_sticky: assert property (@(posedge clk) disable iff (rst)
        (ovf_o && !clr_ovf_i) |=> ovf_o);

    // R9
    a_r9_hi_sticky: assert property (@(posedge clk) disable iff (rst)
        (ovf2_o && !clr_ovf2_i) |=> ovf2_o);

    // R8
    a_r8_flag_needs_run: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf_o) |-> $past(run_i));

    // R5
    a_r5_hi_flag_split_only: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf2_o) |-> ($past(mode_i) == 2'd3));

endmodule

bind tmr_quad_unit tmr_quad_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .mode_i     (mode_i),
    .run_i      (run_i),
    .gate_en_i  (gate_en_i),
    .gate_i     (gate_i),
    .wr_lo_i    (wr_lo_i),
    .wr_hi_i    (wr_hi_i),
    .clr_ovf_i  (clr_ovf_i),
    .clr_ovf2_i (clr_ovf2_i),
    .cnt_lo_o   (cnt_lo_o),
    .cnt_hi_o   (cnt_hi_o),
    .ovf_o      (ovf_o),
    .ovf2_o     (ovf2_o)
);

// File: tb/sim_tmr_quad_unit.sv
module sim_tmr_quad_unit;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] mode_i = 2'd1;
    logic       run_i = 1'b0, hi_run_i = 1'b0, ext_sel_i = 1'b0;
    logic       gate_en_i = 1'b0, gate_i = 1'b0, tick_i = 1'b0, ext_i = 1'b1;
    logic       wr_lo_i = 1'b0, wr_hi_i = 1'b0;
    logic [7:0] wdata_i = 8'h00;
    logic       clr_ovf_i = 1'b0, clr_ovf2_i = 1'b0;
    logic [7:0] cnt_lo_o, cnt_hi_o;
    logic       ovf_o, ovf2_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    tmr_quad_unit u0 (.*);

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input bit hi, input logic [7:0] d);
        @(negedge clk);
        wr_hi_i = hi; wr_lo_i = !hi; wdata_i = d;
        @(negedge clk);
        wr_hi_i = 1'b0; wr_lo_i = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_i = 1'b1;
            @(negedge clk); tick_i = 1'b0;
        end
    endtask

    task automatic clr_flags();
        @(negedge clk); clr_ovf_i = 1'b1; clr_ovf2_i = 1'b1;
        @(negedge clk); clr_ovf_i = 1'b0; clr_ovf2_i = 1'b0;
    endtask

    task automatic setup(input logic [1:0] m, input logic [7:0] hi, input logic [7:0] lo);
        @(negedge clk);
        mode_i = m; run_i = 1'b1; hi_run_i = 1'b0; ext_sel_i = 1'b0;
        gate_en_i = 1'b0; gate_i = 1'b0; tick_i = 1'b0;
        wr(1'b1, hi);
        wr(1'b0, lo);
        clr_flags();
    endtask

    task automatic t_reset();
        run_i = 1'b1; tick_i = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 lo", cnt_lo_o, 0); chk("R1 hi", cnt_hi_o, 0);
        chk("R1 ovf", ovf_o, 0);   chk("R1 ovf2", ovf2_o, 0);
        tick_i = 1'b0; rst = 1'b0;
        @(negedge clk);
        chk("R1 after release", {cnt_hi_o, cnt_lo_o}, 0);
    endtask

    task automatic t_full16();
        setup(2'd1, 8'h12, 8'hFD);
        ticks(4);
        chk("R2 carry", {cnt_hi_o, cnt_lo_o}, 16'h1301);
        chk("R2 no ovf", ovf_o, 0);
        setup(2'd1, 8'hFF, 8'hFE);
        ticks(2);
        chk("R2 rollover", {cnt_hi_o, cnt_lo_o}, 16'h0000);
        chk("R2 ovf", ovf_o, 1);
    endtask

    task automatic t_pre13();
        setup(2'd0, 8'h00, 8'hFE);
        ticks(2);
        chk("R3 prescale wrap lo", cnt_lo_o, 8'hE0);
        chk("R3 prescale carry hi", cnt_hi_o, 8'h01);
        chk("R3 no ovf", ovf_o, 0);
        setup(2'd0, 8'hFF, 8'h1F);
        ticks(1);
        chk("R3 top wrap", {cnt_hi_o, cnt_lo_o}, 16'h0000);
        chk("R3 ovf", ovf_o, 1);
    endtask

    task automatic t_reload8();
        setup(2'd2, 8'h80, 8'hFE);
        ticks(2);
        chk("R4 reloaded lo", cnt_lo_o, 8'h80);
        chk("R4 hi kept", cnt_hi_o, 8'h80);
        chk("R4 ovf", ovf_o, 1);
        ticks(3);
        chk("R4 counts from reload", cnt_lo_o, 8'h83);
    endtask

    task automatic t_split();
        setup(2'd3, 8'hFE, 8'h10);
        run_i = 1'b0; hi_run_i = 1'b1;
        ticks(2);
        chk("R5 hi independent", cnt_hi_o, 8'h00);
        chk("R5 lo held", cnt_lo_o, 8'h10);
        chk("R5 ovf2", ovf2_o, 1);
        chk("R5 main flag untouched", ovf_o, 0);
        run_i = 1'b1; hi_run_i = 1'b0;
        wr(1'b0, 8'hFF);
        ticks(1);
        chk("R5 lo wrap", cnt_lo_o, 8'h00);
        chk("R5 hi stopped", cnt_hi_o, 8'h00);
        chk("R5 ovf", ovf_o, 1);
    endtask

    task automatic t_ext();
        setup(2'd1, 8'h00, 8'h00);
        @(negedge clk); ext_sel_i = 1'b1; tick_i = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); ext_i = 1'b0;
            repeat (4) @(negedge clk);
            ext_i = 1'b1;
            repeat (4) @(negedge clk);
        end
        chk("R6 edges counted, ticks ignored", {cnt_hi_o, cnt_lo_o}, 3);
        tick_i = 1'b0; ext_sel_i = 1'b0;
    endtask

    task automatic t_gate_run();
        setup(2'd1, 8'h00, 8'h20);
        gate_en_i = 1'b1; gate_i = 1'b0;
        ticks(5);
        chk("R7 gate closed", cnt_lo_o, 8'h20);
        gate_i = 1'b1;
        ticks(5);
        chk("R7 gate open", cnt_lo_o, 8'h25);
        gate_en_i = 1'b0; run_i = 1'b0;
        ticks(4);
        chk("R8 run low", cnt_lo_o, 8'h25);
    endtask

    task automatic t_flags();
        setup(2'd2, 8'h00, 8'hFF);
        ticks(1);
        repeat (3) @(negedge clk);
        chk("R9 sticky", ovf_o, 1);
        clr_flags();
        chk("R9 cleared", ovf_o, 0);
        wr(1'b0, 8'hFF);
        @(negedge clk); tick_i = 1'b1; clr_ovf_i = 1'b1;
        @(negedge clk); tick_i = 1'b0; clr_ovf_i = 1'b0;
        chk("R9 set beats clear", ovf_o, 1);
    endtask

    task automatic t_write_prio();
        setup(2'd1, 8'h05, 8'h07);
        @(negedge clk); tick_i = 1'b1; wr_lo_i = 1'b1; wdata_i = 8'h40;
        @(negedge clk); tick_i = 1'b0; wr_lo_i = 1'b0;
        chk("R10 write beats step", {cnt_hi_o, cnt_lo_o}, 16'h0540);
        setup(2'd3, 8'h10, 8'h20);
        hi_run_i = 1'b1;
        @(negedge clk); tick_i = 1'b1; wr_lo_i = 1'b1; wdata_i = 8'h99;
        @(negedge clk); tick_i = 1'b0; wr_lo_i = 1'b0;
        chk("R10 split lo written", cnt_lo_o, 8'h99);
        chk("R10 split hi steps", cnt_hi_o, 8'h11);
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_full16();
        t_pre13();
        t_reload8();
        t_split();
        t_ext();
        t_gate_run();
        t_flags();
        t_write_prio();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule